// File: doc/BRIEF.md
# Odd-First Parallel Prefix Adder

This block adds two unsigned operands of a configurable width and returns the sum together with a carry-out. No carry-in is taken. It is built as a parallel prefix adder. Each bit first forms a generate/propagate pair. A prefix network then resolves the group carries, and a final XOR stage forms the sum bits.

The prefix network works in two phases. The first phase resolves the carries at odd bit positions only. It uses a fixed seed topology that keeps the number of logic levels at ceil(log2 WIDTH) and drives each node into at most two non-trivial loads. The second phase fills in each even position from a nearby odd result. A parameter selects one of two forms for this second phase, and they differ only in how they load the odd outputs.

The adder sits between two register stages, so a chip can place it on a timed path with a fixed two-edge latency.

Top module: `pfx_adder_reg`

## Requirements
- R1: For each bit i, generate is a_i AND b_i and propagate is a_i XOR b_i. The two are never set together.
- R2: Two adjacent spans merge as G = G_hi OR (P_hi AND G_lo) and P = P_hi AND P_lo.
- R3: The carry of position i equals the group generate over bits i down to 0, and the carry of bit 0 is g_0. Adding 1 to an all-ones operand carries through every position.
- R4: Odd carries come from a seed network. The first step covers levels 1 to ceil(log2 WIDTH). At level l it places a node at each odd index x with x >= 3 (for l = 1) or x >= 2^l + 2^(l-1) + 1 (for l > 1). That node spans x down to x-2^l+1 and joins nodes (x,l-1) and (x-2^(l-1),l-1). The second step joins the highest node at x with the finished odd output just below that node's span. Bit 1 is x_1 merged with x_0.
- R5: With EVEN_PAIRED=0, even carry i (i>0) is x_i merged with the carry of i-1. With EVEN_PAIRED=1 it is (x_i merged with x_(i-1)) merged with the prefix output of i-2. Both settings give identical sums.
- R6: Sum bit s_0 = p_0, and s_i = p_i XOR c_(i-1) for i > 0. The carry-out is c_(WIDTH-1), so {cout,sum} equals A+B.
- R7: Operands are captured on one rising edge, and the matching sum and carry-out appear on the following rising edge.
- R8: Asserting the active-low reset clears the captured operands, the sum and the carry-out to zero at once, without waiting for a clock.
- R9: Any WIDTH of 2 or more works, including widths that are not powers of two. The seed then begins at the highest odd index below WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry-out |

## Verification
The bench runs several instances side by side: widths of 5, 8, 13, 16, 32 and 64, with both even-carry forms. It drives a walking carry chain through every bit position. A misplaced seed node or a wrong lower-operand index would then give a wrong sum from the first bit whose span is computed badly, and a wrong even-fill index would corrupt only the even bits. All-ones plus one and alternating bit patterns separate a broken propagate path from a broken generate path. The odd widths catch a seed loop that starts at the wrong top index. A mid-run reset and a one-shot latency probe show whether the result arrives a cycle early or late, or survives a reset.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  function automatic gp_t gp_join(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // lowest odd index that carries a first-step node at level lv
  function automatic int seed_stop(int lv);
    if (lv <= 1) return 3;
    return (1 << lv) + (1 << (lv - 1)) + 1;
  endfunction

  // highest first-step level present at odd index x
  function automatic int top_level(int x, int nlv);
    int h;
    h = 0;
    for (int l = 1; l <= nlv; l++)
      if (x >= seed_stop(l)) h = l;
    return h;
  endfunction

endpackage

// File: rtl/pfx_bitgen.sv
module pfx_bitgen
  import pfx_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output gp_t  [WIDTH-1:0] x
);

  for (genvar i = 0; i < WIDTH; i++) begin : gen_bit
    assign x[i].g = a[i] & b[i];
    assign x[i].p = a[i] ^ b[i];

    always_comb begin
      assert_gp_exclusive_R1: assert (!(x[i].g && x[i].p))
        else $error("bit %0d has generate and propagate both set", i);
    end
  end

endmodule

// File: rtl/pfx_odd_net.sv
module pfx_odd_net
  import pfx_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  gp_t [WIDTH-1:0]   x,
  output gp_t [WIDTH/2-1:0] odd_out
);

  localparam int NLV  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int NODD = WIDTH / 2;

  logic [WIDTH-1:0] pv;
  always_comb begin
    for (int i = 0; i < WIDTH; i++) pv[i] = x[i].p;
  end

  // first seed step: level 0 holds the raw odd inputs; a missing node
  // is carried forward so the top level holds the highest node per index
  for (genvar l = 0; l <= NLV; l++) begin : gen_lv
    for (genvar k = 0; k < NODD; k++) begin : gen_k
      localparam int XI = 2 * k + 1;
      gp_t nd;
      if (l == 0) begin : g_leaf
        assign nd = x[XI];
      end else if (XI >= seed_stop(l) && l == 1) begin : g_l1
        assign nd = gp_join(gen_lv[0].gen_k[k].nd, x[XI-1]);
      end else if (XI >= seed_stop(l)) begin : g_ln
        localparam int LO_K = k - (1 << (l - 2));
        assign nd = gp_join(gen_lv[l-1].gen_k[k].nd, gen_lv[l-1].gen_k[LO_K].nd);
        always_comb begin
          assert_span_prop_R4: assert (nd.p == (&pv[XI -: (1 << l)]))
            else $error("seed node %0d/%0d span propagate wrong", XI, l);
        end
      end else begin : g_pass
        assign nd = gen_lv[l-1].gen_k[k].nd;
      end
    end
  end

  // second seed step: close each odd index down to bit 0
  for (genvar k = 0; k < NODD; k++) begin : gen_out
    localparam int XI = 2 * k + 1;
    localparam int HL = top_level(XI, NLV);
    gp_t nd;
    if (k == 0) begin : g_b1
      assign nd = gp_join(x[1], x[0]);
    end else begin : g_bn
      localparam int LO_K = (XI - (1 << HL) - 1) / 2;
      assign nd = gp_join(gen_lv[NLV].gen_k[k].nd, gen_out[LO_K].nd);
    end
    assign odd_out[k] = nd;
  end

endmodule

// File: rtl/pfx_even_fill.sv
module pfx_even_fill
  import pfx_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit EVEN_PAIRED = 1'b0
) (
  input  gp_t  [WIDTH-1:0]   x,
  input  gp_t  [WIDTH/2-1:0] odd_out,
  output logic [WIDTH-1:0]   carry
);

  localparam int NODD = WIDTH / 2;
  localparam int NEV  = (WIDTH + 1) / 2;

  logic [WIDTH-1:0] pv;
  logic [WIDTH-1:0] pre_p;
  always_comb begin
    for (int i = 0; i < WIDTH; i++) pv[i] = x[i].p;
    pre_p[0] = pv[0];
    for (int i = 1; i < WIDTH; i++) pre_p[i] = pre_p[i-1] & pv[i];
  end

  for (genvar k = 0; k < NODD; k++) begin : gen_odd_c
    assign carry[2*k+1] = odd_out[k].g;
    always_comb begin
      assert_odd_prop_R4: assert (odd_out[k].p == pre_p[2*k+1])
        else $error("odd output %0d group propagate wrong", 2*k+1);
    end
  end

  for (genvar e = 0; e < NEV; e++) begin : gen_ev
    localparam int XI = 2 * e;
    gp_t nd;
    if (e == 0) begin : g_b0
      assign nd = x[0];
    end else if (EVEN_PAIRED) begin : g_pair
      gp_t pair;
      assign pair = gp_join(x[XI], x[XI-1]);
      assign nd   = gp_join(pair, gen_ev[e-1].nd);
    end else begin : g_direct
      assign nd = gp_join(x[XI], odd_out[e-1]);
    end
    assign carry[XI] = nd.g;

    always_comb begin
      assert_even_prop_R5: assert (nd.p == pre_p[XI])
        else $error("even output %0d group propagate wrong", XI);
      assert_even_gen_R5: assert (!x[XI].g || nd.g)
        else $error("even output %0d lost a local generate", XI);
    end
  end

endmodule

// File: rtl/pfx_sum.sv
module pfx_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] g,
  input  logic [WIDTH-1:0] p,
  input  logic [WIDTH-1:0] carry,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  assign sum[0] = p[0];
  for (genvar i = 1; i < WIDTH; i++) begin : gen_s
    assign sum[i] = p[i] ^ carry[i-1];

    always_comb begin
      assert_carry_chain_R3: assert (carry[i] == (g[i] | (p[i] & carry[i-1])))
        else $error("carry %0d breaks the ripple recurrence", i);
    end
  end
  assign cout = carry[WIDTH-1];

  always_comb begin
    assert_carry_base_R3: assert (carry[0] == g[0])
      else $error("carry 0 differs from g0");
  end

endmodule

// File: rtl/pfx_adder_reg.sv
module pfx_adder_reg
  import pfx_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit EVEN_PAIRED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NODD = WIDTH / 2;

  logic [WIDTH-1:0] a_q, b_q, a_d, b_d;
  logic [WIDTH-1:0] sum_q, sum_d, sum_c;
  logic             cout_q, cout_d, cout_c;

  gp_t  [WIDTH-1:0] x;
  gp_t  [NODD-1:0]  odd_out;
  logic [WIDTH-1:0] carry;
  logic [WIDTH-1:0] gv, pv;

  // next-state
  always_comb begin
    a_d    = a;
    b_d    = b;
    sum_d  = sum_c;
    cout_d = cout_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

  pfx_bitgen #(.WIDTH(WIDTH)) u_bitgen (
    .a (a_q),
    .b (b_q),
    .x (x)
  );

  pfx_odd_net #(.WIDTH(WIDTH)) u_odd (
    .x       (x),
    .odd_out (odd_out)
  );

  pfx_even_fill #(.WIDTH(WIDTH), .EVEN_PAIRED(EVEN_PAIRED)) u_even (
    .x       (x),
    .odd_out (odd_out),
    .carry   (carry)
  );

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      gv[i] = x[i].g;
      pv[i] = x[i].p;
    end
  end

  pfx_sum #(.WIDTH(WIDTH)) u_sum (
    .g     (gv),
    .p     (pv),
    .carry (carry),
    .sum   (sum_c),
    .cout  (cout_c)
  );

  assign sum  = sum_q;
  assign cout = cout_q;

  always_comb begin
    assert_comb_add_R6: assert ({cout_c, sum_c} == ({1'b0, a_q} + {1'b0, b_q}))
      else $error("combinational sum differs from A+B");
  end

  assert_one_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({cout_q, sum_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)})))
    else $error("registered result not aligned to captured operands");

endmodule

// File: tb/pfx_adder_reg_tb_top.sv
`timescale 1ns/1ps
module pfx_adder_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] a, b;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  bit          chk_en = 1'b0;
  string       tag = "R6";
  logic [127:0] hist[$];

  always #2.5 clk = ~clk;

  logic [15:0] s16; logic c16;
  logic [7:0]  s8;  logic c8;
  logic [12:0] s13; logic c13;
  logic [31:0] s32; logic c32;
  logic [63:0] s64; logic c64;
  logic [4:0]  s5;  logic c5;

  pfx_adder_reg #(.WIDTH(16), .EVEN_PAIRED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .a(a[15:0]), .b(b[15:0]), .sum(s16), .cout(c16));
  pfx_adder_reg #(.WIDTH(8), .EVEN_PAIRED(1'b1)) dut_w8 (
    .clk(clk), .rst_n(rst_n), .a(a[7:0]), .b(b[7:0]), .sum(s8), .cout(c8));
  pfx_adder_reg #(.WIDTH(13), .EVEN_PAIRED(1'b0)) dut_w13 (
    .clk(clk), .rst_n(rst_n), .a(a[12:0]), .b(b[12:0]), .sum(s13), .cout(c13));
  pfx_adder_reg #(.WIDTH(32), .EVEN_PAIRED(1'b1)) dut_w32 (
    .clk(clk), .rst_n(rst_n), .a(a[31:0]), .b(b[31:0]), .sum(s32), .cout(c32));
  pfx_adder_reg #(.WIDTH(64), .EVEN_PAIRED(1'b0)) dut_w64 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sum(s64), .cout(c64));
  pfx_adder_reg #(.WIDTH(5), .EVEN_PAIRED(1'b1)) dut_w5 (
    .clk(clk), .rst_n(rst_n), .a(a[4:0]), .b(b[4:0]), .sum(s5), .cout(c5));

  function automatic logic [64:0] ref_add(int w, logic [63:0] x, logic [63:0] y);
    logic [64:0] m, r;
    m = (65'd1 << w) - 65'd1;
    r = {1'b0, x & m[63:0]} + {1'b0, y & m[63:0]};
    return r & ((65'd1 << (w + 1)) - 65'd1);
  endfunction

  task automatic check(string t, int w, logic [64:0] act, logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s W=%0d actual=%h expected=%h", t, w, act, exp);
    end
  endtask

  // reference model: one queued operand pair per rising edge
  always @(posedge clk) begin
    if (rst_n) hist.push_back({a, b});
  end

  always @(negedge clk) begin
    if (rst_n && chk_en && hist.size() >= 2) begin
      logic [63:0] ra, rb;
      {ra, rb} = hist[hist.size()-2];
      // R7: result reflects operands captured one edge earlier
      check(tag, 16, {48'd0, c16, s16}, ref_add(16, ra, rb));
      check(tag, 8,  {56'd0, c8,  s8},  ref_add(8,  ra, rb));
      check(tag, 13, {51'd0, c13, s13}, ref_add(13, ra, rb));
      check(tag, 32, {32'd0, c32, s32}, ref_add(32, ra, rb));
      check(tag, 64, {c64, s64},        ref_add(64, ra, rb));
      check(tag, 5,  {59'd0, c5,  s5},  ref_add(5,  ra, rb));
      while (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic check_zero(string t);
    check(t, 16, {48'd0, c16, s16}, 65'd0);
    check(t, 8,  {56'd0, c8,  s8},  65'd0);
    check(t, 13, {51'd0, c13, s13}, 65'd0);
    check(t, 64, {c64, s64},        65'd0);
  endtask

  task automatic drive(logic [63:0] x, logic [63:0] y, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a = x;
      b = y;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(negedge clk);
    check_zero("R8 reset state");
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R3: all-ones plus one, and all-ones plus all-ones
    tag = "R3";
    drive('1, 64'd1, 3);
    drive('1, '1, 3);
    drive(64'd0, 64'd0, 2);

    // R1: alternating patterns, pure propagate and pure generate
    tag = "R1";
    drive(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 3);
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 3);
    drive(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 3);

    // R4 R5 R9: walking carry chain ending at every bit position
    tag = "R4 R5 R9 walk";
    for (int pos = 0; pos < 64; pos++) begin
      drive((64'd1 << pos) - 64'd1, 64'd1, 1);
    end
    for (int pos = 0; pos < 64; pos++) begin
      drive(64'd1 << pos, 64'd1 << pos, 1);
    end

    // R2 R6: random operands
    tag = "R2 R6 random";
    for (int i = 0; i < 400; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1);
    end
    drive(64'd0, 64'd0, 3);

    // R7: explicit latency probe on the 16-bit instance
    @(negedge clk);
    a = 64'd1;
    b = 64'd2;
    @(negedge clk);
    a = 64'd0;
    b = 64'd0;
    check("R7 before result edge", 16, {48'd0, c16, s16}, 65'd0);
    @(negedge clk);
    check("R7 result edge", 16, {48'd0, c16, s16}, 65'd3);
    @(negedge clk);
    check("R7 result gone", 16, {48'd0, c16, s16}, 65'd0);

    // R8: asynchronous reset in mid-run
    tag = "R6";
    drive('1, '1, 3);
    chk_en = 1'b0;
    rst_n = 1'b0;
    #1;
    check_zero("R8 async clear");
    hist.delete();
    repeat (2) @(negedge clk);
    check_zero("R8 held");
    rst_n = 1'b1;
    chk_en = 1'b1;
    tag = "R6 after reset";
    for (int i = 0; i < 20; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1);
    end
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule